// File: doc/BRIEF.md
# Banked Scratch RAM with Hardware Stack

This block is the small internal data store of an 8-bit controller core. It holds a flat array of bytes that can be read and written by direct address. The lowest part of the array is also reachable as eight working registers, and a two-bit bank field picks which group of eight bytes those registers mean. A stack pointer register lives beside the array. Pushes and pops move bytes through that pointer into the same storage, so the stack and the register banks can overlap if software lets them.

All three read ports are combinational. Writes commit on the rising clock edge. When two write sources target the same byte in one cycle, a fixed priority decides which one lands.

Reset is asynchronous and active low. It is released through a two-flop synchronizer, so the block leaves reset two rising edges after `rst_n` goes high. The stack pointer then holds 07h, which means the first push writes to byte 08h.

Top module: `banked_scratch_ram`

## Requirements
- R1: After reset is released, `sp_q` reads 07h and both `ovf_flag` and `unf_flag` are low.
- R2: A direct write with `dir_wr_en` stores `dir_wdata` at `dir_addr`. From the next cycle, `dir_rdata` returns that byte for every address 00h–7Fh.
- R3: Register index n (0–7) under bank select b (0–3) addresses byte b*8+n. Register writes and reads through `reg_wdata`/`reg_rdata` use that same byte as the direct port does.
- R4: A push (`push_req` alone) first increments `sp_q` and then stores `stk_wdata` at the new pointer. After reset, the first push lands at 08h.
- R5: `pop_data` always shows the byte at `sp_q`. A pop (`pop_req` alone) then decrements `sp_q`, so bytes come back last-in, first-out.
- R6: A push while `sp_q` is 7Fh wraps the pointer to 00h, writes byte 00h, and raises `ovf_flag` in the following cycle.
- R7: A pop while `sp_q` is 00h wraps the pointer to 7Fh and raises `unf_flag` in the following cycle.
- R8: When a register write and a direct write hit the same byte in one cycle, the register data is stored.
- R9: When a push hits the same byte as a register write or a direct write in one cycle, the pushed data is stored.
- R10: `sp_wr_en` loads `sp_wdata` into the pointer. A push or pop in the same cycle is ignored: the pointer does not step and no byte is written.
- R11: A push and a pop requested in the same cycle cancel. The pointer is unchanged and no byte is written.
- R12: Each flag is a one-cycle pulse. It is low in any cycle that does not directly follow a wrapping push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_addr | input | 7 | Direct byte address |
| dir_wr_en | input | 1 | Direct write enable |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Byte at `dir_addr` |
| reg_idx | input | 3 | Working register index |
| bank_sel | input | 2 | Register bank select |
| reg_wr_en | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Byte of the selected register |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| stk_wdata | input | 8 | Byte to push |
| pop_data | output | 8 | Byte at the stack pointer |
| sp_wr_en | input | 1 | Stack pointer load enable |
| sp_wdata | input | 7 | Stack pointer load value |
| sp_q | output | 7 | Current stack pointer |
| ovf_flag | output | 1 | Push wrapped past 7Fh (pulse) |
| unf_flag | output | 1 | Pop wrapped below 00h (pulse) |

## Verification
The bench uses the default parameters: a 7-bit address (128 bytes), 8-bit data, a 3-bit register index, a 2-bit bank select and a reset pointer of 07h. With these values it can write and read back every byte of the array, and it covers all 32 bank/index combinations. The pointer load lets a few cycles reach both wrap edges, so the overflow and underflow pulses are checked. The same load places the pointer next to register bytes and ordinary bytes, so every write-collision priority can be tested.

// File: rtl/bkram_pkg.sv
package bkram_pkg;
  // Action the stack pointer takes in a cycle
  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_LOAD = 2'd1,
    SP_INC  = 2'd2,
    SP_DEC  = 2'd3
  } sp_op_e;
endpackage

// File: rtl/bkram_rst_sync.sv
module bkram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bkram_sp_ctrl.sv
module bkram_sp_ctrl
  import bkram_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int SP_RST = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] sp_q,
  output logic              push_we,
  output logic [ADDR_W-1:0] push_addr,
  output logic              ovf_q,
  output logic              unf_q
);
  localparam logic [ADDR_W-1:0] SP_TOP  = '1;
  localparam logic [ADDR_W-1:0] SP_INIT = ADDR_W'(SP_RST);

  sp_op_e            op;
  logic [ADDR_W-1:0] sp_n;
  logic              sp_en;
  logic              ovf_n;
  logic              unf_n;

  // Decide the pointer action: a load wins, and push with pop cancels out
  always_comb begin
    if (load_en)                 op = SP_LOAD;
    else if (push_req && !pop_req) op = SP_INC;
    else if (pop_req && !push_req) op = SP_DEC;
    else                         op = SP_HOLD;
  end

  always_comb begin
    sp_n = sp_q;
    unique case (op)
      SP_LOAD: sp_n = load_val;
      SP_INC:  sp_n = sp_q + 1'b1;
      SP_DEC:  sp_n = sp_q - 1'b1;
      default: sp_n = sp_q;
    endcase
    sp_en = (op != SP_HOLD);
    ovf_n = (op == SP_INC) && (sp_q == SP_TOP);
    unf_n = (op == SP_DEC) && (sp_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_INIT;
    else if (sp_en) sp_q <= sp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_n;
      unf_q <= unf_n;
    end
  end

  assign push_we   = (op == SP_INC);
  assign push_addr = sp_q + 1'b1;
endmodule

// File: rtl/bkram_store.sv
module bkram_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              stk_we,
  input  logic [ADDR_W-1:0] stk_waddr,
  input  logic [DATA_W-1:0] stk_wdata,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              dir_we,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [DATA_W-1:0] dir_wdata,
  input  logic [ADDR_W-1:0] stk_raddr,
  output logic [DATA_W-1:0] dir_rdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] stk_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  ent_we;
  logic [DATA_W-1:0] ent_wd [DEPTH];

  // Per-byte write select: stack first, then register, then direct
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit_s, hit_r, hit_d;
    assign hit_s     = stk_we && (stk_waddr == ADDR_W'(e));
    assign hit_r     = reg_we && (reg_addr  == ADDR_W'(e));
    assign hit_d     = dir_we && (dir_addr  == ADDR_W'(e));
    assign ent_we[e] = hit_s | hit_r | hit_d;
    assign ent_wd[e] = hit_s ? stk_wdata : (hit_r ? reg_wdata : dir_wdata);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (ent_we[k]) mem[k] <= ent_wd[k];
    end
  end

  assign dir_rdata = mem[dir_addr];
  assign reg_rdata = mem[reg_addr];
  assign stk_rdata = mem[stk_raddr];
endmodule

// File: rtl/banked_scratch_ram.sv
module banked_scratch_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int BANK_W = 2,
  parameter int SP_RST = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic              dir_wr_en,
  input  logic [DATA_W-1:0] dir_wdata,
  output logic [DATA_W-1:0] dir_rdata,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] stk_wdata,
  output logic [DATA_W-1:0] pop_data,
  input  logic              sp_wr_en,
  input  logic [ADDR_W-1:0] sp_wdata,
  output logic [ADDR_W-1:0] sp_q,
  output logic              ovf_flag,
  output logic              unf_flag
);
  localparam int REG_SPAN_W = BANK_W + IDX_W;

  logic              rst_sync_n;
  logic              push_we_raw;
  logic [ADDR_W-1:0] push_addr;
  logic [ADDR_W-1:0] reg_addr;

  // Register operand aliasing: bank in the upper bits, index below
  assign reg_addr = ADDR_W'({bank_sel, reg_idx});

  bkram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bkram_sp_ctrl #(.ADDR_W(ADDR_W), .SP_RST(SP_RST)) u_sp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .load_en   (sp_wr_en),
    .load_val  (sp_wdata),
    .sp_q      (sp_q),
    .push_we   (push_we_raw),
    .push_addr (push_addr),
    .ovf_q     (ovf_flag),
    .unf_q     (unf_flag)
  );

  bkram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk       (clk),
    .stk_we    (push_we_raw & rst_sync_n),
    .stk_waddr (push_addr),
    .stk_wdata (stk_wdata),
    .reg_we    (reg_wr_en & rst_sync_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dir_we    (dir_wr_en & rst_sync_n),
    .dir_addr  (dir_addr),
    .dir_wdata (dir_wdata),
    .stk_raddr (sp_q),
    .dir_rdata (dir_rdata),
    .reg_rdata (reg_rdata),
    .stk_rdata (pop_data)
  );

  if (REG_SPAN_W > ADDR_W) begin : g_bad_span
    initial $error("register banks exceed the address range");
  end
endmodule

// File: rtl/bkram_chk.sv
module bkram_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_req,
  input logic              pop_req,
  input logic              sp_wr_en,
  input logic [ADDR_W-1:0] sp_wdata,
  input logic [DATA_W-1:0] stk_wdata,
  input logic [ADDR_W-1:0] sp_q,
  input logic [DATA_W-1:0] pop_data,
  input logic              ovf_flag,
  input logic              unf_flag
);
  localparam logic [ADDR_W-1:0] SP_TOP = '1;

  logic do_push, do_pop;
  assign do_push = push_req && !pop_req && !sp_wr_en;
  assign do_pop  = pop_req && !push_req && !sp_wr_en;

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> sp_q == ADDR_W'($past(sp_q) + 1'b1)); // R4

  AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> pop_data == $past(stk_wdata)); // R9

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> sp_q == ADDR_W'($past(sp_q) - 1'b1)); // R5

  AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |=> sp_q == $past(sp_wdata)); // R10

  AST_PUSH_POP_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !sp_wr_en) |=> $stable(sp_q)); // R11

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(do_push && sp_q == SP_TOP)); // R6

  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_flag) |-> $past(do_pop && sp_q == '0)); // R7

  AST_FLAG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag || unf_flag) |=> !(ovf_flag && $past(!do_push)) && !(unf_flag && $past(!do_pop))); // R12
endmodule

bind banked_scratch_ram bkram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .sp_wr_en  (sp_wr_en),
  .sp_wdata  (sp_wdata),
  .stk_wdata (stk_wdata),
  .sp_q      (sp_q),
  .pop_data  (pop_data),
  .ovf_flag  (ovf_flag),
  .unf_flag  (unf_flag)
);

// File: tb/banked_scratch_ram_tb.sv
module banked_scratch_ram_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] dir_addr;
  logic       dir_wr_en;
  logic [7:0] dir_wdata;
  logic [7:0] dir_rdata;
  logic [2:0] reg_idx;
  logic [1:0] bank_sel;
  logic       reg_wr_en;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       push_req;
  logic       pop_req;
  logic [7:0] stk_wdata;
  logic [7:0] pop_data;
  logic       sp_wr_en;
  logic [6:0] sp_wdata;
  logic [6:0] sp_q;
  logic       ovf_flag;
  logic       unf_flag;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #2.5 clk = ~clk;

  banked_scratch_ram u_dut (
    .clk(clk), .rst_n(rst_n),
    .dir_addr(dir_addr), .dir_wr_en(dir_wr_en), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
    .reg_idx(reg_idx), .bank_sel(bank_sel), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .push_req(push_req), .pop_req(pop_req), .stk_wdata(stk_wdata), .pop_data(pop_data),
    .sp_wr_en(sp_wr_en), .sp_wdata(sp_wdata), .sp_q(sp_q),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    dir_wr_en = 0; reg_wr_en = 0; push_req = 0; pop_req = 0; sp_wr_en = 0;
  endtask

  task automatic dwrite(input logic [6:0] a, input logic [7:0] d);
    dir_addr = a; dir_wdata = d; dir_wr_en = 1; step(); idle();
  endtask

  function automatic int dread(input logic [6:0] a);
    dir_addr = a;
    return 0;
  endfunction

  task automatic peek(input logic [6:0] a, output logic [7:0] d);
    dir_addr = a; #0.1; d = dir_rdata;
  endtask

  task automatic sp_load(input logic [6:0] v);
    sp_wdata = v; sp_wr_en = 1; step(); idle();
  endtask

  task automatic t_reset();
    check("R1 sp after reset", sp_q, 7'h07);
    check("R1 ovf after reset", ovf_flag, 0);
    check("R1 unf after reset", unf_flag, 0);
  endtask

  task automatic t_direct();
    logic [7:0] d;
    for (int i = 0; i < 128; i++) dwrite(7'(i), 8'(i) ^ 8'h5A);
    for (int i = 0; i < 128; i++) begin
      peek(7'(i), d);
      check("R2 direct readback", d, (i ^ 8'h5A) & 8'hFF);
    end
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        bank_sel = 2'(b); reg_idx = 3'(n);
        reg_wdata = 8'(8'h80 + b * 8 + n); reg_wr_en = 1; step(); idle();
      end
    end
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        peek(7'(b * 8 + n), d);
        check("R3 register alias at bank*8+n", d, 8'h80 + b * 8 + n);
      end
    end
    dwrite(7'h1A, 8'hC3);
    bank_sel = 2'd3; reg_idx = 3'd2; #0.1;
    check("R3 register read of direct byte", reg_rdata, 8'hC3);
  endtask

  task automatic t_stack();
    logic [7:0] d;
    rst_n = 0; step(); rst_n = 1; step(); step();
    check("R1 sp after second reset", sp_q, 7'h07);
    stk_wdata = 8'hA1; push_req = 1; step(); idle();
    check("R4 sp after first push", sp_q, 7'h08);
    peek(7'h08, d);
    check("R4 first push lands at 08h", d, 8'hA1);
    check("R12 ovf low after plain push", ovf_flag, 0);
    stk_wdata = 8'hA2; push_req = 1; step(); idle();
    stk_wdata = 8'hA3; push_req = 1; step(); idle();
    check("R4 sp after three pushes", sp_q, 7'h0A);
    check("R5 pop_data top", pop_data, 8'hA3);
    pop_req = 1; step(); idle();
    check("R5 sp after pop", sp_q, 7'h09);
    check("R5 LIFO second", pop_data, 8'hA2);
    pop_req = 1; step(); idle();
    check("R5 LIFO third", pop_data, 8'hA1);
    check("R12 unf low after plain pop", unf_flag, 0);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    sp_load(7'h7F);
    check("R10 sp load", sp_q, 7'h7F);
    stk_wdata = 8'h77; push_req = 1; step(); idle();
    check("R6 sp wraps to 00h", sp_q, 7'h00);
    check("R6 ovf pulse", ovf_flag, 1);
    peek(7'h00, d);
    check("R6 wrapped push writes 00h", d, 8'h77);
    step();
    check("R12 ovf drops after one cycle", ovf_flag, 0);
    check("R5 pop_data at 00h", pop_data, 8'h77);
    pop_req = 1; step(); idle();
    check("R7 sp wraps to 7Fh", sp_q, 7'h7F);
    check("R7 unf pulse", unf_flag, 1);
    check("R12 ovf stays low on underflow", ovf_flag, 0);
    step();
    check("R12 unf drops after one cycle", unf_flag, 0);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    dir_addr = 7'h13; dir_wdata = 8'h11; dir_wr_en = 1;
    bank_sel = 2'd2; reg_idx = 3'd3; reg_wdata = 8'h22; reg_wr_en = 1;
    step(); idle();
    peek(7'h13, d);
    check("R8 register beats direct", d, 8'h22);
    sp_load(7'h2F);
    dir_addr = 7'h30; dir_wdata = 8'h44; dir_wr_en = 1;
    stk_wdata = 8'h33; push_req = 1; step(); idle();
    peek(7'h30, d);
    check("R9 push beats direct", d, 8'h33);
    sp_load(7'h0F);
    bank_sel = 2'd2; reg_idx = 3'd0; reg_wdata = 8'h55; reg_wr_en = 1;
    stk_wdata = 8'h66; push_req = 1; step(); idle();
    peek(7'h10, d);
    check("R9 push beats register", d, 8'h66);
  endtask

  task automatic t_load_block();
    logic [7:0] d;
    dwrite(7'h41, 8'h12);
    dwrite(7'h51, 8'h34);
    sp_load(7'h40);
    sp_wdata = 7'h50; sp_wr_en = 1; stk_wdata = 8'h99; push_req = 1; step(); idle();
    check("R10 load wins over push", sp_q, 7'h50);
    peek(7'h41, d);
    check("R10 no push write at old sp+1", d, 8'h12);
    peek(7'h51, d);
    check("R10 no push write at new sp+1", d, 8'h34);
    sp_wdata = 7'h20; sp_wr_en = 1; pop_req = 1; step(); idle();
    check("R10 load wins over pop", sp_q, 7'h20);
  endtask

  task automatic t_push_pop();
    logic [7:0] d;
    dwrite(7'h21, 8'h6B);
    stk_wdata = 8'hEE; push_req = 1; pop_req = 1; step(); idle();
    check("R11 sp unchanged", sp_q, 7'h20);
    peek(7'h21, d);
    check("R11 no write", d, 8'h6B);
    check("R12 flags low", {ovf_flag, unf_flag}, 0);
  endtask

  initial begin
    rst_n = 0; idle();
    dir_addr = 0; dir_wdata = 0; reg_idx = 0; bank_sel = 0; reg_wdata = 0;
    stk_wdata = 0; sp_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(); step(); step();
    t_reset();
    t_direct();
    t_regmap();
    t_stack();
    t_wrap();
    t_priority();
    t_load_block();
    t_push_pop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule